// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Sticky Error Flags

This block receives asynchronous serial frames on a single input line. A frame is one low start bit, eight data bits with the least significant bit first, an optional parity bit and one high stop bit. Each bit lasts sixteen ticks of an internal divider. The line passes through a two-flop synchronizer. The start bit is confirmed at its middle, and every later bit is sampled at its middle.

A finished frame is shifted into a holding register and then either copied to the data output or thrown away. Four sticky flags report the outcome: data ready, overrun, framing error and parity error. Software clears a flag by writing 0 to its bit.

An error never hides the byte that caused it. A frame with a bad stop bit or bad parity still lands in the data register, but it does not raise the ready flag. An overrun keeps the earlier byte. While any error flag is set, completed frames are dropped. The receiver keeps running through a line break, so the framing flag comes back after software clears it.

Top module: `serial_rx_core`

## Requirements
- R1: After reset, `rx_data` is 0 and all four flags are 0.
- R2: A frame with a good stop bit and good parity, arriving while all flags are 0, loads its byte into `rx_data` (first data bit goes to bit 0) and sets `sts_full`. `sts_full` then stays 1 until software clears it.
- R3: A frame that completes while `sts_full` is 1 and no error flag is set leaves `rx_data` unchanged, sets `sts_ovr` and keeps `sts_full` at 1.
- R4: A frame whose stop bit is sampled low, arriving while all flags are 0, loads its byte into `rx_data`, sets `sts_frm` and leaves `sts_full` at 0.
- R5: A frame with only a parity mismatch, arriving while all flags are 0, loads its byte into `rx_data`, sets `sts_par` and leaves `sts_full` at 0.
- R6: A frame with both a low stop bit and a parity mismatch, arriving while all flags are 0, loads its byte, sets `sts_frm` and `sts_par`, and leaves `sts_full` at 0.
- R7: An erroneous frame that completes while `sts_full` is 1 sets `sts_ovr` and each flag matching its error. `sts_full` stays 1 and `rx_data` is unchanged.
- R8: While `sts_ovr`, `sts_frm` or `sts_par` is 1, a completed frame changes neither `rx_data` nor any flag.
- R9: When `par_en` is 1, the parity bit follows the last data bit. It is expected to make the count of ones over the data and parity bits even when `par_odd` is 0, and odd when `par_odd` is 1. When `par_en` is 0, there is no parity bit and `sts_par` is never set.
- R10: While the line is held low, `sts_frm` sets. If software clears it during the break, it sets again on a later frame. With odd parity selected, `sts_par` also sets.
- R11: A low pulse shorter than half a bit period, seen at the middle of the start bit as high, starts no frame and changes no output.
- R12: A write with `csr_wr` at 1 clears each flag whose bit in `csr_wdata` is 0 and leaves a flag unchanged where the bit is 1. The bit positions are 3 for ready, 2 for overrun, 1 for framing and 0 for parity. A flag being set by a frame in the same cycle wins over its clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rxd | input | 1 | Serial line, idles high |
| par_en | input | 1 | Static: a parity bit follows the data |
| par_odd | input | 1 | Static: 1 selects odd parity, 0 selects even |
| csr_wr | input | 1 | Status write strobe |
| csr_wdata | input | 4 | Status write data; a 0 bit clears that flag |
| rx_data | output | 8 | Receive data register |
| sts_full | output | 1 | Data ready flag |
| sts_ovr | output | 1 | Overrun flag |
| sts_frm | output | 1 | Framing error flag |
| sts_par | output | 1 | Parity error flag |

## Verification
The bench goes after the error combinations.

- If a framing or parity error set the ready flag, software would take a bad byte as good.
- If an overrun copied the new byte, it would destroy the byte still waiting to be read.
- If a frame were accepted while an error flag is set, `rx_data` would change under software that has not yet looked at the error.

A held-low line, with the framing flag cleared in the middle, shows whether the receiver keeps running during a break. A short low pulse shows whether the mid-bit start check rejects glitches. Frames in both parity modes, and with parity turned off, show whether the parity sense is right and whether the parity flag stays quiet when parity is disabled.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;
  typedef enum logic [2:0] {
    RX_IDLE  = 3'd0,
    RX_START = 3'd1,
    RX_DATA  = 3'd2,
    RX_PAR   = 3'd3,
    RX_STOP  = 3'd4
  } rx_state_e;

  // bit positions in the status write word
  localparam int unsigned FLG_FULL = 3;
  localparam int unsigned FLG_OVR  = 2;
  localparam int unsigned FLG_FRM  = 1;
  localparam int unsigned FLG_PAR  = 0;
  localparam int unsigned FLG_W    = 4;
endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_in,
  output logic d_out
);
  logic [STAGES-1:0] pipe_q;
  logic [STAGES-1:0] pipe_n;

  always_comb begin
    pipe_n = {pipe_q[STAGES-2:0], d_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '1;
    else        pipe_q <= pipe_n;
  end

  assign d_out = pipe_q[STAGES-1];
endmodule

// File: rtl/rx_tick.sv
module rx_tick #(
  parameter int DIV = 27
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q, cnt_n;
  logic          tick_n;

  always_comb begin
    tick_n = (cnt_q == LAST);
    cnt_n  = tick_n ? '0 : cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  assign tick = tick_n;
endmodule

// File: rtl/rx_framer.sv
module rx_framer
  import serial_rx_pkg::*;
#(
  parameter int OVS    = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              rxd_s,
  input  logic              par_en,
  input  logic              par_odd,
  output logic              frm_done,
  output logic [DATA_W-1:0] frm_data,
  output logic              frm_stop_bad,
  output logic              frm_par_bad
);
  localparam int CW = $clog2(OVS);
  localparam int BW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CW-1:0] MID_CNT = CW'(OVS / 2 - 1);
  localparam logic [CW-1:0] END_CNT = CW'(OVS - 1);
  localparam logic [BW-1:0] LAST_BIT = BW'(DATA_W - 1);

  rx_state_e         st_q, st_n;
  logic [CW-1:0]     cnt_q, cnt_n;
  logic [BW-1:0]     bit_q, bit_n;
  logic [DATA_W-1:0] sh_q, sh_n;
  logic              perr_q, perr_n;
  logic              done_q, done_n;
  logic              fe_q, fe_n;
  logic              pe_q, pe_n;
  logic              at_mid, at_end;

  assign at_mid = (cnt_q == MID_CNT);
  assign at_end = (cnt_q == END_CNT);

  always_comb begin
    st_n   = st_q;
    cnt_n  = cnt_q;
    bit_n  = bit_q;
    sh_n   = sh_q;
    perr_n = perr_q;
    fe_n   = fe_q;
    pe_n   = pe_q;
    done_n = 1'b0;
    if (tick) begin
      case (st_q)
        RX_IDLE: begin
          if (!rxd_s) begin
            st_n  = RX_START;
            cnt_n = '0;
          end
        end
        RX_START: begin
          if (at_mid) begin
            cnt_n  = '0;
            bit_n  = '0;
            perr_n = 1'b0;
            st_n   = rxd_s ? RX_IDLE : RX_DATA;
          end else begin
            cnt_n = cnt_q + CW'(1);
          end
        end
        RX_DATA: begin
          if (at_end) begin
            cnt_n = '0;
            sh_n  = {rxd_s, sh_q[DATA_W-1:1]};
            if (bit_q == LAST_BIT) st_n = par_en ? RX_PAR : RX_STOP;
            else                   bit_n = bit_q + BW'(1);
          end else begin
            cnt_n = cnt_q + CW'(1);
          end
        end
        RX_PAR: begin
          if (at_end) begin
            cnt_n  = '0;
            perr_n = (^sh_q) ^ rxd_s ^ par_odd;
            st_n   = RX_STOP;
          end else begin
            cnt_n = cnt_q + CW'(1);
          end
        end
        RX_STOP: begin
          if (at_end) begin
            cnt_n  = '0;
            done_n = 1'b1;
            fe_n   = ~rxd_s;
            pe_n   = perr_q & par_en;
            st_n   = RX_IDLE;
          end else begin
            cnt_n = cnt_q + CW'(1);
          end
        end
        default: st_n = RX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= RX_IDLE;
      cnt_q  <= '0;
      bit_q  <= '0;
      sh_q   <= '0;
      perr_q <= 1'b0;
      done_q <= 1'b0;
      fe_q   <= 1'b0;
      pe_q   <= 1'b0;
    end else begin
      st_q   <= st_n;
      cnt_q  <= cnt_n;
      bit_q  <= bit_n;
      sh_q   <= sh_n;
      perr_q <= perr_n;
      done_q <= done_n;
      fe_q   <= fe_n;
      pe_q   <= pe_n;
    end
  end

  assign frm_done     = done_q;
  assign frm_data     = sh_q;
  assign frm_stop_bad = fe_q;
  assign frm_par_bad  = pe_q;
endmodule

// File: rtl/serial_rx_core.sv
module serial_rx_core
  import serial_rx_pkg::*;
#(
  parameter int CLK_DIV     = 27,
  parameter int OVS         = 16,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rxd,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              csr_wr,
  input  logic [FLG_W-1:0]  csr_wdata,
  output logic [DATA_W-1:0] rx_data,
  output logic              sts_full,
  output logic              sts_ovr,
  output logic              sts_frm,
  output logic              sts_par
);
  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  logic              rxd_s, tick;
  logic              f_done, f_fe, f_pe;
  logic [DATA_W-1:0] f_data;

  rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_int_n), .d_in(rxd), .d_out(rxd_s)
  );

  rx_tick #(.DIV(CLK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_int_n), .tick(tick)
  );

  rx_framer #(.OVS(OVS), .DATA_W(DATA_W)) u_framer (
    .clk(clk), .rst_n(rst_int_n), .tick(tick), .rxd_s(rxd_s),
    .par_en(par_en), .par_odd(par_odd),
    .frm_done(f_done), .frm_data(f_data),
    .frm_stop_bad(f_fe), .frm_par_bad(f_pe)
  );

  logic [DATA_W-1:0] data_q, data_n;
  logic              full_q, full_n, ovr_q, ovr_n, frm_q, frm_n, par_q, par_n;
  logic [FLG_W-1:0]  keep;
  logic              accept, xfer;

  always_comb begin
    keep   = csr_wr ? csr_wdata : '1;
    accept = f_done & ~(ovr_q | frm_q | par_q);
    xfer   = accept & ~full_q;
    data_n = xfer ? f_data : data_q;
    full_n = (full_q & keep[FLG_FULL]) | (xfer & ~f_fe & ~f_pe);
    ovr_n  = (ovr_q  & keep[FLG_OVR])  | (accept & full_q);
    frm_n  = (frm_q  & keep[FLG_FRM])  | (accept & f_fe);
    par_n  = (par_q  & keep[FLG_PAR])  | (accept & f_pe);
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      data_q <= '0;
      full_q <= 1'b0;
      ovr_q  <= 1'b0;
      frm_q  <= 1'b0;
      par_q  <= 1'b0;
    end else begin
      data_q <= data_n;
      full_q <= full_n;
      ovr_q  <= ovr_n;
      frm_q  <= frm_n;
      par_q  <= par_n;
    end
  end

  assign rx_data  = data_q;
  assign sts_full = full_q;
  assign sts_ovr  = ovr_q;
  assign sts_frm  = frm_q;
  assign sts_par  = par_q;
endmodule

// File: rtl/serial_rx_core_sva.sv
module serial_rx_core_sva #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              par_en,
  input logic              csr_wr,
  input logic [3:0]        csr_wdata,
  input logic [DATA_W-1:0] rx_data,
  input logic              sts_full,
  input logic              sts_ovr,
  input logic              sts_frm,
  input logic              sts_par
);
  // R3 / R7: an overrun only arises on top of a waiting byte
  p_ovr_needs_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts_ovr) |-> $past(sts_full));

  // R3: the waiting byte survives an overrun
  p_ovr_keeps_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts_ovr) |-> $stable(rx_data));

  // R4 / R5: an error without overrun never raises the ready flag
  p_err_no_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (($rose(sts_frm) || $rose(sts_par)) && !sts_ovr) |-> !sts_full);

  // R8: outstanding errors freeze the data register
  p_err_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_ovr || sts_frm || sts_par) |=> $stable(rx_data));

  // R9: parity flag can only rise with parity enabled
  p_par_off_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts_par) |-> $past(par_en));

  // R12: the ready flag falls only on a clearing write
  p_full_clear_write_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sts_full) |-> ($past(csr_wr) && !$past(csr_wdata[3])));
endmodule

bind serial_rx_core serial_rx_core_sva #(.DATA_W(DATA_W)) u_sva (
  .clk(clk), .rst_n(rst_n), .par_en(par_en), .csr_wr(csr_wr),
  .csr_wdata(csr_wdata), .rx_data(rx_data), .sts_full(sts_full),
  .sts_ovr(sts_ovr), .sts_frm(sts_frm), .sts_par(sts_par)
);

// File: tb/serial_rx_core_tb_top.sv
`timescale 1ns/1ps
module serial_rx_core_tb_top;
  localparam int DIV = 4;
  localparam int BIT = 16 * DIV;
  localparam int WD_LIMIT = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rxd = 1'b1;
  logic       par_en = 1'b1;
  logic       par_odd = 1'b0;
  logic       csr_wr = 1'b0;
  logic [3:0] csr_wdata = 4'h0;
  logic [7:0] rx_data;
  logic       sts_full, sts_ovr, sts_frm, sts_par;

  always #2.5 clk = ~clk;

  serial_rx_core #(.CLK_DIV(DIV)) dut_i (
    .clk(clk), .rst_n(rst_n), .rxd(rxd), .par_en(par_en), .par_odd(par_odd),
    .csr_wr(csr_wr), .csr_wdata(csr_wdata), .rx_data(rx_data),
    .sts_full(sts_full), .sts_ovr(sts_ovr), .sts_frm(sts_frm), .sts_par(sts_par)
  );

  int    total = 0;
  int    bad = 0;
  int    cycles = 0;
  string cur_req = "R1";
  bit    cmp_en = 1'b0;
  bit    guard = 1'b0;

  // reference state
  logic [7:0] m_data = 8'h00;
  bit         m_full = 0, m_ovr = 0, m_frm = 0, m_par = 0;

  function automatic void model_frame(input logic [7:0] d, input bit fe, input bit pe);
    if (m_ovr || m_frm || m_par) return;
    if (m_full) begin
      m_ovr = 1;
      if (fe) m_frm = 1;
      if (pe) m_par = 1;
    end else begin
      m_data = d;
      if (fe) m_frm = 1;
      if (pe) m_par = 1;
      if (!fe && !pe) m_full = 1;
    end
  endfunction

  // per-clock comparison against the reference
  always @(negedge clk) begin
    if (cmp_en && !guard) begin
      total++;
      if (rx_data !== m_data || sts_full !== m_full || sts_ovr !== m_ovr ||
          sts_frm !== m_frm || sts_par !== m_par) begin
        bad++;
        $display("FAIL %s model: got data=%02h f=%b o=%b fe=%b pe=%b exp data=%02h f=%b o=%b fe=%b pe=%b",
                 cur_req, rx_data, sts_full, sts_ovr, sts_frm, sts_par,
                 m_data, m_full, m_ovr, m_frm, m_par);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WD_LIMIT) begin
      bad++;
      total++;
      $display("FAIL watchdog: got cycles=%0d exp below %0d", cycles, WD_LIMIT);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic expect_st(input string req, input logic [7:0] d,
                           input bit f, input bit o, input bit fe, input bit pe);
    @(negedge clk);
    total++;
    if (rx_data !== d || sts_full !== f || sts_ovr !== o || sts_frm !== fe || sts_par !== pe) begin
      bad++;
      $display("FAIL %s: got data=%02h f=%b o=%b fe=%b pe=%b exp data=%02h f=%b o=%b fe=%b pe=%b",
               req, rx_data, sts_full, sts_ovr, sts_frm, sts_par, d, f, o, fe, pe);
    end
  endtask

  task automatic drive_bit(input logic v);
    rxd <= v;
    repeat (BIT) @(posedge clk);
  endtask

  // par_flip inverts the correct parity bit; stop_v is the stop level
  task automatic send_frame(input logic [7:0] d, input bit par_flip, input bit stop_v);
    drive_bit(1'b0);
    for (int i = 0; i < 8; i++) drive_bit(d[i]);
    if (par_en) drive_bit((^d) ^ par_odd ^ par_flip);
    rxd   <= stop_v;
    guard = 1'b1;
    repeat (3 * BIT / 4) @(posedge clk);
    model_frame(d, !stop_v, par_en && par_flip);
    guard = 1'b0;
    repeat (BIT / 4) @(posedge clk);
    rxd <= 1'b1;
    repeat (BIT / 2) @(posedge clk);
  endtask

  task automatic csr_write(input logic [3:0] v);
    @(posedge clk);
    csr_wr    <= 1'b1;
    csr_wdata <= v;
    @(posedge clk);
    csr_wr <= 1'b0;
    m_full = m_full & v[3];
    m_ovr  = m_ovr & v[2];
    m_frm  = m_frm & v[1];
    m_par  = m_par & v[0];
  endtask

  initial begin
    repeat (4) @(posedge clk);
    expect_st("R1", 8'h00, 0, 0, 0, 0);
    @(posedge clk);
    rst_n <= 1'b1;
    repeat (6) @(posedge clk);
    expect_st("R1", 8'h00, 0, 0, 0, 0);
    cmp_en = 1'b1;

    cur_req = "R2";
    send_frame(8'hA5, 0, 1);
    expect_st("R2", 8'hA5, 1, 0, 0, 0);
    repeat (200) @(posedge clk);
    expect_st("R2", 8'hA5, 1, 0, 0, 0);

    cur_req = "R12";
    csr_write(4'b1111);
    expect_st("R12", 8'hA5, 1, 0, 0, 0);
    csr_write(4'b0111);
    expect_st("R12", 8'hA5, 0, 0, 0, 0);

    cur_req = "R3";
    send_frame(8'h3C, 0, 1);
    send_frame(8'h5A, 0, 1);
    expect_st("R3", 8'h3C, 1, 1, 0, 0);

    cur_req = "R8";
    send_frame(8'h11, 0, 1);
    expect_st("R8", 8'h3C, 1, 1, 0, 0);
    csr_write(4'b0000);

    cur_req = "R4";
    send_frame(8'hC3, 0, 0);
    expect_st("R4", 8'hC3, 0, 0, 1, 0);
    cur_req = "R8";
    send_frame(8'h77, 0, 1);
    expect_st("R8", 8'hC3, 0, 0, 1, 0);
    cur_req = "R12";
    csr_write(4'b1101);
    expect_st("R12", 8'hC3, 0, 0, 0, 0);

    cur_req = "R5";
    send_frame(8'h96, 1, 1);
    expect_st("R5", 8'h96, 0, 0, 0, 1);
    csr_write(4'b0000);

    cur_req = "R6";
    send_frame(8'h0F, 1, 0);
    expect_st("R6", 8'h0F, 0, 0, 1, 1);
    csr_write(4'b0000);

    cur_req = "R7";
    send_frame(8'h42, 0, 1);
    send_frame(8'h24, 1, 0);
    expect_st("R7", 8'h42, 1, 1, 1, 1);
    csr_write(4'b0000);
    send_frame(8'h99, 0, 1);
    send_frame(8'h66, 1, 1);
    expect_st("R7", 8'h99, 1, 1, 0, 1);
    csr_write(4'b0000);

    cur_req = "R11";
    rxd <= 1'b0;
    repeat (2 * DIV) @(posedge clk);
    rxd <= 1'b1;
    repeat (3 * BIT) @(posedge clk);
    expect_st("R11", 8'h99, 0, 0, 0, 0);
    send_frame(8'h5E, 0, 1);
    expect_st("R11", 8'h5E, 1, 0, 0, 0);
    csr_write(4'b0000);

    cur_req = "R9";
    par_odd <= 1'b1;
    repeat (4) @(posedge clk);
    send_frame(8'h81, 0, 1);
    expect_st("R9", 8'h81, 1, 0, 0, 0);
    csr_write(4'b0000);
    send_frame(8'h81, 1, 1);
    expect_st("R9", 8'h81, 0, 0, 0, 1);
    csr_write(4'b0000);
    par_en <= 1'b0;
    repeat (4) @(posedge clk);
    send_frame(8'hE7, 0, 1);
    expect_st("R9", 8'hE7, 1, 0, 0, 0);
    csr_write(4'b0000);
    send_frame(8'h18, 0, 0);
    expect_st("R9", 8'h18, 0, 0, 1, 0);
    csr_write(4'b0000);
    par_en <= 1'b1;
    repeat (4) @(posedge clk);

    cur_req = "R10";
    cmp_en = 1'b0;
    rxd <= 1'b0;
    repeat (3000) @(posedge clk);
    expect_st("R10", 8'h00, 0, 0, 1, 1);
    csr_write(4'b1100);
    expect_st("R10", 8'h00, 0, 0, 0, 0);
    repeat (1600) @(posedge clk);
    expect_st("R10", 8'h00, 0, 0, 1, 1);
    rxd <= 1'b1;
    repeat (1600) @(posedge clk);
    csr_write(4'b0000);
    m_data = 8'h00; m_full = 0; m_ovr = 0; m_frm = 0; m_par = 0;
    expect_st("R10", 8'h00, 0, 0, 0, 0);
    cmp_en = 1'b1;

    cur_req = "R2";
    send_frame(8'hFF, 0, 1);
    expect_st("R2", 8'hFF, 1, 0, 0, 0);

    repeat (20) @(posedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule